// File: doc/BRIEF.md
# Direction-Switched Byte FIFO with Threshold Request and Sticky Status

This block is the byte buffer between a register-mapped data port and a serial bus engine. One input picks which way data flows. In transmit mode the processor writes bytes into the FIFO and the engine pops them. In receive mode the engine pushes bytes and the processor reads them out. The oldest byte is always visible on one output, so a pop and its data arrive in the same cycle. The bus protocol is not part of this block. The engine sees only push and pop strobes.

Two level comparisons raise a data-request flag, and which one applies depends on direction. In receive mode the flag rises once enough bytes have arrived. In transmit mode it rises once the buffer has drained far enough. A self-clearing flush strobe empties the FIFO. Misuse of the data port is recorded in sticky error bits, and so is the engine's end-of-transfer pulse. Software clears every status bit by writing a one to it.

Top module: `ddc_byte_fifo`

## Requirements
- R1: While reset is asserted, `fill_level` is 0, `status` is 0 and `flush_busy` is 0.
- R2: In transmit mode (`rx_mode`=0), bytes written with `cpu_wr` are presented on `head_byte` and removed by `eng_pop` in the order they were written.
- R3: In receive mode (`rx_mode`=1), bytes pushed with `eng_push` are presented on `head_byte` and removed by `cpu_rd` in arrival order. The byte being read is on `head_byte` in the same cycle as `cpu_rd`.
- R4: In receive mode, request status bit 0 becomes 1 on the clock after `fill_level` is greater than `rx_level`.
- R5: In transmit mode, request status bit 0 becomes 1 on the clock after `fill_level` is less than `tx_level`.
- R6: A `flush` pulse raises `flush_busy` for exactly one cycle. After that cycle `fill_level` is 0. Pushes and pops presented while `flush_busy` is 1 have no effect.
- R7: Each status bit is cleared by a one in the same position of `status_w1c`, and a zero leaves it alone. If the request condition still holds, bit 0 reads 0 for one cycle after the clear and is set again on the next clock.
- R8: Event bits 1 to 4 are set rather than cleared when their event arrives in the same cycle as the clear for that bit.
- R9: In receive mode, `cpu_rd` on an empty FIFO sets status bit 3 (underflow), and `fill_level` stays at 0.
- R10: In transmit mode, `cpu_wr` on a full FIFO sets status bit 4 (overflow). The stored bytes and `fill_level` are not changed.
- R11: A `cpu_wr` in receive mode or a `cpu_rd` in transmit mode sets status bit 2 (illegal access). Neither one changes `fill_level` or `head_byte`.
- R12: An `xfer_done` pulse sets status bit 1 (transfer complete).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_mode | input | 1 | 1 = engine fills, processor drains; 0 = processor fills, engine drains |
| rx_level | input | LW | Receive request threshold |
| tx_level | input | LW | Transmit request threshold |
| flush | input | 1 | Flush strobe (write of one to the clear bit) |
| flush_busy | output | 1 | Clear bit readback, self-clearing |
| cpu_wr | input | 1 | Processor write to data port |
| cpu_wdata | input | 8 | Processor write byte |
| cpu_rd | input | 1 | Processor read from data port |
| eng_push | input | 1 | Engine delivers a received byte |
| eng_wdata | input | 8 | Engine received byte |
| eng_pop | input | 1 | Engine takes the head byte for sending |
| head_byte | output | 8 | Oldest stored byte |
| fill_level | output | LW | Bytes stored |
| xfer_done | input | 1 | Engine end-of-transfer pulse |
| status_w1c | input | 5 | Write-one-to-clear mask for status |
| status | output | 5 | {overflow, underflow, illegal, done, request} |

## Verification
Two of the block's functions can fall in the same cycle: a software clear of a status bit and a fresh hardware event for that same bit. The bench drives an empty-FIFO read and a `xfer_done` pulse in the same cycle as the clear mask for those bits and expects both bits to read 1 afterwards. The request bit resolves the other way. It is cleared while its condition still holds, and the bench expects a single cycle at 0 followed by a return to 1. Request behaviour is swept over every pairing of fill level and threshold, in both directions, on a four-deep instance.

// File: rtl/ddc_byte_fifo.sv
module ddc_byte_fifo #(
  parameter int DEPTH = 16,
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_mode,
  input  logic [LW-1:0] rx_level,
  input  logic [LW-1:0] tx_level,
  input  logic          flush,
  output logic          flush_busy,
  input  logic          cpu_wr,
  input  logic [7:0]    cpu_wdata,
  input  logic          cpu_rd,
  input  logic          eng_push,
  input  logic [7:0]    eng_wdata,
  input  logic          eng_pop,
  output logic [7:0]    head_byte,
  output logic [LW-1:0] fill_level,
  input  logic          xfer_done,
  input  logic [4:0]    status_w1c,
  output logic [4:0]    status
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [LW-1:0] FULL = LW'(DEPTH);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wp, rp;

  wire full  = fill_level == FULL;
  wire empty = fill_level == '0;

  wire want_push = rx_mode ? eng_push : cpu_wr;
  wire want_pop  = rx_mode ? cpu_rd   : eng_pop;
  wire do_push   = !flush_busy && want_push && !full;
  wire do_pop    = !flush_busy && want_pop && !empty;
  wire [7:0] push_byte = rx_mode ? eng_wdata : cpu_wdata;

  wire ev_ovf = !flush_busy && !rx_mode && cpu_wr && full;
  wire ev_udf = !flush_busy && rx_mode && cpu_rd && empty;
  wire ev_ill = (rx_mode && cpu_wr) || (!rx_mode && cpu_rd);
  wire req_hit = rx_mode ? (fill_level > rx_level) : (fill_level < tx_level);
  wire [4:1] ev = {ev_ovf, ev_udf, ev_ill, xfer_done};

  assign head_byte = mem[rp];

  always_ff @(posedge clk)
    if (do_push) mem[wp] <= push_byte;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
      fill_level <= '0;
      flush_busy <= 1'b0;
    end else if (flush_busy) begin
      wp <= '0;
      rp <= '0;
      fill_level <= '0;
      flush_busy <= 1'b0;
    end else begin
      flush_busy <= flush;
      if (do_push) wp <= (wp == LAST) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
      fill_level <= fill_level + LW'(do_push) - LW'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) status <= '0;
    else begin
      status[0]   <= status_w1c[0] ? 1'b0 : (status[0] | req_hit);
      status[4:1] <= (status[4:1] & ~status_w1c[4:1]) | ev;
    end
  end
endmodule

// File: rtl/ddc_byte_fifo_chk.sv
module ddc_byte_fifo_chk #(
  parameter int DEPTH = 16,
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_mode,
  input logic [LW-1:0] rx_level,
  input logic [LW-1:0] tx_level,
  input logic          flush_busy,
  input logic          cpu_wr,
  input logic          cpu_rd,
  input logic [LW-1:0] fill_level,
  input logic          xfer_done,
  input logic [4:0]    status_w1c,
  input logic [4:0]    status
);
  p_level_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fill_level <= LW'(DEPTH));

  p_req_rx_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_mode && fill_level > rx_level && !status_w1c[0]) |=> status[0]);

  p_req_tx_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_mode && fill_level < tx_level && !status_w1c[0]) |=> status[0]);

  p_flush_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flush_busy |=> (!flush_busy && fill_level == '0));

  p_req_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    status_w1c[0] |=> !status[0]);

  p_done_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && status_w1c[1]) |=> status[1]);

  p_underflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_mode && cpu_rd && fill_level == '0 && !flush_busy) |=> (status[3] && fill_level == '0));

  p_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_mode && cpu_wr && fill_level == LW'(DEPTH) && !flush_busy) |=> status[4]);

  p_illegal_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ((rx_mode && cpu_wr) || (!rx_mode && cpu_rd)) |=> status[2]);

  p_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> status[1]);
endmodule

bind ddc_byte_fifo ddc_byte_fifo_chk #(.DEPTH(DEPTH), .LW(LW)) chk_i (
  .clk(clk), .rst_n(rst_n), .rx_mode(rx_mode), .rx_level(rx_level),
  .tx_level(tx_level), .flush_busy(flush_busy), .cpu_wr(cpu_wr),
  .cpu_rd(cpu_rd), .fill_level(fill_level), .xfer_done(xfer_done),
  .status_w1c(status_w1c), .status(status)
);

// File: tb/ddc_byte_fifo_tb_top.sv
module ddc_byte_fifo_tb_top;
  localparam int D = 4;
  localparam int LW = $clog2(D + 1);

  logic clk = 0, rst_n = 0;
  logic rx_mode = 1, flush = 0, cpu_wr = 0, cpu_rd = 0, eng_push = 0, eng_pop = 0, xfer_done = 0;
  logic [LW-1:0] rx_level = LW'(D), tx_level = '0;
  logic [7:0] cpu_wdata = 0, eng_wdata = 0;
  logic [4:0] status_w1c = 0;
  logic flush_busy;
  logic [7:0] head_byte;
  logic [LW-1:0] fill_level;
  logic [4:0] status;
  int errs = 0, checks = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  ddc_byte_fifo #(.DEPTH(D)) dut_i (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick; @(negedge clk); endtask

  task automatic do_flush;
    flush = 1; tick; flush = 0;
    chk(flush_busy == 1, "R6 busy", flush_busy, 1);
    tick;
    chk(flush_busy == 0 && fill_level == 0, "R6 empty", fill_level, 0);
  endtask

  task automatic clr_all;
    status_w1c = 5'h1f; tick; status_w1c = 0;
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  initial begin
    #3000000;
    errs++; checks++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_run();
  end

  initial begin
    tick; tick;
    chk(fill_level == 0, "R1 level", fill_level, 0);
    chk(status == 0, "R1 status", status, 0);
    chk(flush_busy == 0, "R1 busy", flush_busy, 0);
    rst_n = 1; tick;

    // R4 / R5 / R7 sweep over every level/threshold pair
    for (int m = 0; m < 2; m++) begin
      rx_mode = (m == 0);
      for (int l = 0; l <= D; l++) begin
        for (int t = 0; t <= D; t++) begin
          rx_level = LW'(t); tx_level = LW'(t);
          do_flush;
          for (int k = 0; k < l; k++) begin
            if (rx_mode) begin eng_push = 1; eng_wdata = 8'(k); end
            else begin cpu_wr = 1; cpu_wdata = 8'(k); end
            tick;
            eng_push = 0; cpu_wr = 0;
          end
          clr_all;
          chk(status[0] == 0, "R7 req cleared", status[0], 0);
          tick;
          if (rx_mode) chk(status[0] == (l > t), "R4 req rx", status[0], int'(l > t));
          else         chk(status[0] == (l < t), "R5 req tx", status[0], int'(l < t));
        end
      end
    end
    rx_level = LW'(D); tx_level = '0;

    // R3 receive order and R9 underflow, R8 same-cycle clear
    rx_mode = 1; do_flush; clr_all;
    for (int k = 0; k < D; k++) begin eng_push = 1; eng_wdata = 8'h30 + 8'(k); tick; end
    eng_push = 0;
    eng_push = 1; eng_wdata = 8'hee; tick; eng_push = 0;
    chk(fill_level == D, "R3 full level", fill_level, D);
    for (int k = 0; k < D; k++) begin
      chk(head_byte == 8'h30 + 8'(k), "R3 order", head_byte, 8'h30 + k);
      cpu_rd = 1; tick; cpu_rd = 0;
    end
    chk(fill_level == 0, "R3 drained", fill_level, 0);
    chk(status[3] == 0, "R9 no early udf", status[3], 0);
    cpu_rd = 1; tick; cpu_rd = 0;
    chk(status[3] == 1, "R9 underflow", status[3], 1);
    chk(fill_level == 0, "R9 level", fill_level, 0);
    status_w1c = 5'b01000; cpu_rd = 1; xfer_done = 1; tick;
    status_w1c = 0; cpu_rd = 0; xfer_done = 0;
    chk(status[3] == 1, "R8 udf wins", status[3], 1);
    chk(status[1] == 1, "R8 done sets", status[1], 1);
    status_w1c = 5'b00010; xfer_done = 1; tick; status_w1c = 0; xfer_done = 0;
    chk(status[1] == 1, "R8 done wins", status[1], 1);
    status_w1c = 5'b00010; tick; status_w1c = 0;
    chk(status[1] == 0, "R7 done cleared", status[1], 0);
    chk(status[3] == 1, "R7 zero keeps", status[3], 1);
    xfer_done = 1; tick; xfer_done = 0;
    chk(status[1] == 1, "R12 done", status[1], 1);

    // R11 illegal in receive mode
    clr_all;
    eng_push = 1; eng_wdata = 8'h51; tick; eng_wdata = 8'h52; tick; eng_push = 0;
    cpu_wr = 1; cpu_wdata = 8'h99; tick; cpu_wr = 0;
    chk(status[2] == 1, "R11 wr in rx", status[2], 1);
    chk(fill_level == 2, "R11 level rx", fill_level, 2);
    chk(head_byte == 8'h51, "R11 head rx", head_byte, 8'h51);

    // R6 push during busy ignored
    flush = 1; tick; flush = 0; eng_push = 1; eng_wdata = 8'h77; tick; eng_push = 0;
    chk(fill_level == 0, "R6 ignore push", fill_level, 0);

    // R2 transmit order, R10 overflow, R11 illegal read
    rx_mode = 0; do_flush; clr_all;
    for (int k = 0; k < D; k++) begin cpu_wr = 1; cpu_wdata = 8'hA0 + 8'(k); tick; end
    cpu_wr = 0;
    chk(status[4] == 0, "R10 no early ovf", status[4], 0);
    cpu_wr = 1; cpu_wdata = 8'h11; tick; cpu_wr = 0;
    chk(status[4] == 1, "R10 overflow", status[4], 1);
    chk(fill_level == D, "R10 level", fill_level, D);
    cpu_rd = 1; tick; cpu_rd = 0;
    chk(status[2] == 1, "R11 rd in tx", status[2], 1);
    chk(fill_level == D, "R11 level tx", fill_level, D);
    for (int k = 0; k < D; k++) begin
      chk(head_byte == 8'hA0 + 8'(k), "R2 order", head_byte, 8'hA0 + k);
      eng_pop = 1; tick; eng_pop = 0;
    end
    chk(fill_level == 0, "R2 drained", fill_level, 0);

    // R7 request re-set while condition holds
    tx_level = LW'(1); tick; clr_all;
    chk(status[0] == 0, "R7 gap", status[0], 0);
    tick;
    chk(status[0] == 1, "R7 reassert", status[0], 1);

    finish_run();
  end
endmodule